// File: doc/BRIEF.md
# Chainable Trace Capture Controller

This block records a stream of wide sample words into an on-chip circular buffer and freezes the contents around a trigger event. Once armed, it writes one sample every clock cycle and wraps around the buffer. A trigger can come from the local match condition or from a rising edge on any bit of an auxiliary trigger bus driven by another monitor, possibly in another clock domain. The block then records a fixed number of further samples and stops. A programmable position value sets how many of the retained samples come before the trigger.

Several controllers can be chained. The trigger output of one controller carries its local match condition, delayed by one cycle, into the auxiliary input of the next. This lets a condition in one clock domain start a capture in another. Both ports are optional and are enabled by parameters. If the monitored interface has no reset of its own, the reset input can be tied inactive and an auxiliary reset can be brought in over the trigger bus at system level.

A small register-style port arms the capture, sets the position and selects a readback index. Readback index 0 is the oldest retained sample, and the trigger sample sits at the index equal to the position value. The capture depth is 2^DEPTH_LOG2. DEPTH_LOG2 is limited to the range 10 to 17, which gives 1024 to 131072 samples.

The controller runs a four-state machine:
- IDLE goes to PRE_TRIG on an arm.
- PRE_TRIG goes to POST_TRIG on a trigger. If no post-trigger samples are left to record, it goes straight to DONE instead. An arm in PRE_TRIG restarts PRE_TRIG.
- POST_TRIG goes to DONE when its last sample is written.
- From POST_TRIG or DONE, an arm returns the machine to PRE_TRIG.

Top module: `trace_capture_ctrl`

## Requirements
- R1: While reset is asserted, and after it, the controller sits in IDLE with st_armed, st_triggered, st_done and trig_out all 0.
- R2: A write to address 0 with bit 0 set arms the capture. After the next edge, the write pointer is 0, st_armed=1 and st_done=0. This holds from any state, and it clears a finished capture.
- R3: A trigger, local or auxiliary, has no effect while the block is in IDLE or DONE. The status outputs and the stored samples stay unchanged.
- R4: In PRE_TRIG, local_trig high at an edge makes the sample taken at that edge the trigger sample. st_done rises exactly DEPTH-1-P edges later, where P is the position value written to address 1. When P = DEPTH-1, st_done rises at that same edge.
- R5: A write to address 2 with value i selects readback index i. Two edges later, rd_data holds the sample at index i. Index 0 is the oldest retained sample, and index P holds the trigger sample, provided at least P samples were written before the trigger.
- R6: Each auxiliary trigger bit passes through a two-flop synchronizer and a rising-edge detector. When a bit is first sampled high at edge e, the sample taken at edge e+2 becomes the trigger sample. A level that stays high does not trigger again.
- R7: trig_out equals local_trig as it was at the previous edge, regardless of the capture state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| sample_in | input | SAMPLE_W | Sample word recorded each cycle |
| local_trig | input | 1 | Local match condition |
| aux_trig_in | input | AUX_W | Auxiliary triggers from other monitors, may be asynchronous |
| trig_out | output | 1 | Registered local condition for chaining |
| ctl_we | input | 1 | Register write strobe |
| ctl_addr | input | 2 | 0 arm, 1 position, 2 readback index, 3 unused |
| ctl_wdata | input | DEPTH_LOG2 | Register write value |
| rd_data | output | SAMPLE_W | Sample at the selected readback index |
| st_armed | output | 1 | In PRE_TRIG or POST_TRIG |
| st_triggered | output | 1 | In POST_TRIG or DONE |
| st_done | output | 1 | In DONE |

## Verification
Each result has a fixed latency:
- Status outputs follow an arm one edge later.
- trig_out follows local_trig by one edge.
- A local trigger takes effect at the edge where it is seen high. An auxiliary trigger takes effect two edges after it is first sampled.
- st_done rises DEPTH-1-P edges after the trigger edge.
- Readback data is valid two edges after the index write.

The bench drives inputs on falling edges and counts rising edges from each stimulus. It samples on the falling edge that follows the due edge. For st_done, it also checks that the flag is still low one edge before it is due. For the trigger value, it records the sample word present at the exact edge where the trigger takes effect.

// File: rtl/trc_pkg.sv
package trc_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_PRE,
        CAP_POST,
        CAP_DONE
    } cap_state_t;

    localparam logic [1:0] REG_ARM = 2'd0;
    localparam logic [1:0] REG_POS = 2'd1;
    localparam logic [1:0] REG_IDX = 2'd2;
endpackage

// File: rtl/trc_aux_edge.sv
module trc_aux_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic         rise_any
);
    logic [W-1:0] meta_q, sync_q, prev_q, rise_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_vec = sync_q & ~prev_q;
    assign rise_any = |rise_vec;

    // R6
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_vec != '0) |=> ((rise_vec & $past(rise_vec)) == '0));
endmodule

// File: rtl/trc_sample_ram.sv
module trc_sample_ram #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/trc_capture_fsm.sv
module trc_capture_fsm
    import trc_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          trig,
    input  logic [AW-1:0] pos,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic          armed,
    output logic          triggered,
    output logic          done
);
    localparam logic [AW-1:0] LAST_IDX = {AW{1'b1}};

    cap_state_t    state, state_n;
    logic [AW-1:0] remaining;
    logic          fire;

    assign fire = (state == CAP_PRE) && trig && !arm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            CAP_IDLE: if (arm) state_n = CAP_PRE;
            CAP_PRE: begin
                if (arm) begin
                    state_n = CAP_PRE;
                end else if (trig) begin
                    state_n = (pos == LAST_IDX) ? CAP_DONE : CAP_POST;
                end
            end
            CAP_POST: begin
                if (arm) begin
                    state_n = CAP_PRE;
                end else if (remaining == AW'(1)) begin
                    state_n = CAP_DONE;
                end
            end
            CAP_DONE: if (arm) state_n = CAP_PRE;
            default:  state_n = CAP_IDLE;
        endcase
    end

    always_comb begin
        armed     = (state == CAP_PRE) || (state == CAP_POST);
        triggered = (state == CAP_POST) || (state == CAP_DONE);
        done      = (state == CAP_DONE);
        wr_en     = armed && !arm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            remaining <= '0;
        end else begin
            if (arm) begin
                wr_ptr <= '0;
            end else if (wr_en) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (fire) begin
                remaining <= LAST_IDX - pos;
            end else if (state == CAP_POST && !arm) begin
                remaining <= remaining - AW'(1);
            end
        end
    end

    // R2
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (wr_ptr == '0 && armed && !done));

    // R3
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> (done && $stable(wr_ptr)));

    // R3
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !triggered && !arm) |=> (!armed && !triggered && $stable(wr_ptr)));

    // R4
    post_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_POST) |-> (remaining != '0));
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
    import trc_pkg::*;
#(
    parameter int SAMPLE_W     = 16,
    parameter int DEPTH_LOG2   = 10,
    parameter int AUX_W        = 2,
    parameter bit USE_AUX_IN   = 1'b1,
    parameter bit USE_TRIG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SAMPLE_W-1:0]   sample_in,
    input  logic                  local_trig,
    input  logic [AUX_W-1:0]      aux_trig_in,
    output logic                  trig_out,
    input  logic                  ctl_we,
    input  logic [1:0]            ctl_addr,
    input  logic [DEPTH_LOG2-1:0] ctl_wdata,
    output logic [SAMPLE_W-1:0]   rd_data,
    output logic                  st_armed,
    output logic                  st_triggered,
    output logic                  st_done
);
    localparam int AW = DEPTH_LOG2;

    logic [AW-1:0] pos_q, idx_q, wr_ptr, rd_addr;
    logic          arm, aux_hit, wr_en;

    assign arm = ctl_we && (ctl_addr == REG_ARM) && ctl_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            idx_q <= '0;
        end else if (ctl_we) begin
            if (ctl_addr == REG_POS) pos_q <= ctl_wdata;
            if (ctl_addr == REG_IDX) idx_q <= ctl_wdata;
        end
    end

    generate
        if (USE_AUX_IN) begin : g_aux
            trc_aux_edge #(.W(AUX_W)) i_aux (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (aux_trig_in),
                .rise_any (aux_hit)
            );
        end else begin : g_no_aux
            assign aux_hit = 1'b0 & (|aux_trig_in);
        end

        if (USE_TRIG_OUT) begin : g_tout
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) trig_out <= 1'b0;
                else        trig_out <= local_trig;
            end
            // R7
            trig_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (trig_out == $past(local_trig)));
        end else begin : g_no_tout
            assign trig_out = 1'b0;
        end
    endgenerate

    trc_capture_fsm #(.AW(AW)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .trig      (local_trig | aux_hit),
        .pos       (pos_q),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .armed     (st_armed),
        .triggered (st_triggered),
        .done      (st_done)
    );

    assign rd_addr = wr_ptr + idx_q;

    trc_sample_ram #(.AW(AW), .DW(SAMPLE_W)) i_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (sample_in),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: tb/test_trace_capture_ctrl.sv
module test_trace_capture_ctrl;
    localparam int AW    = 10;
    localparam int SW    = 16;
    localparam int XW    = 2;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] pos;
        logic          use_aux;
        logic          aux_bit;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{pos: 10'd0,    use_aux: 1'b0, aux_bit: 1'b0},
        '{pos: 10'd512,  use_aux: 1'b1, aux_bit: 1'b1},
        '{pos: 10'd1023, use_aux: 1'b0, aux_bit: 1'b0},
        '{pos: 10'd100,  use_aux: 1'b1, aux_bit: 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] smp = '0;
    logic          local_trig = 1'b0;
    logic [XW-1:0] aux = '0;
    logic          trig_out;
    logic          ctl_we = 1'b0;
    logic [1:0]    ctl_addr = '0;
    logic [AW-1:0] ctl_wdata = '0;
    logic [SW-1:0] rd_data;
    logic          st_armed, st_triggered, st_done;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;
    always @(negedge clk) smp <= smp + 16'd1;

    trace_capture_ctrl #(.SAMPLE_W(SW), .DEPTH_LOG2(AW), .AUX_W(XW)) i_trace_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_in(smp), .local_trig(local_trig),
        .aux_trig_in(aux), .trig_out(trig_out), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .rd_data(rd_data), .st_armed(st_armed),
        .st_triggered(st_triggered), .st_done(st_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_addr = a; ctl_wdata = AW'(d);
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic read_idx(input int i, output logic [SW-1:0] v);
        wr(2'd2, i);
        @(negedge clk);
        v = rd_data;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [SW-1:0] tval, got, expv;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!st_armed && !st_triggered && !st_done && !trig_out, "R1",
              {st_armed, st_triggered, st_done, trig_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after release
        check(!st_armed && !st_done, "R1", {st_armed, st_done}, 0);

        // R3: trigger while idle is ignored
        local_trig = 1'b1;
        @(negedge clk);
        local_trig = 1'b0;
        @(negedge clk);
        check(!st_armed && !st_triggered && !st_done, "R3 idle",
              {st_armed, st_triggered, st_done}, 0);

        for (int vi = 0; vi < 4; vi++) begin
            int n_post;
            wr(2'd1, int'(VECS[vi].pos));
            wr(2'd0, 1);
            // R2
            check(st_armed && !st_done && !st_triggered, "R2 arm",
                  {st_armed, st_done, st_triggered}, 3'b100);
            repeat (1100) @(negedge clk);
            if (VECS[vi].use_aux) begin
                aux[VECS[vi].aux_bit] = 1'b1;
                repeat (3) @(posedge clk);
                tval = smp;
            end else begin
                local_trig = 1'b1;
                @(posedge clk);
                tval = smp;
            end
            @(negedge clk);
            local_trig = 1'b0;
            n_post = DEPTH - 1 - int'(VECS[vi].pos);
            if (n_post == 0) begin
                check(st_done, "R4 done at trigger", int'(st_done), 1);
            end else begin
                repeat (n_post - 1) @(negedge clk);
                check(!st_done, VECS[vi].use_aux ? "R6 done early" : "R4 done early",
                      int'(st_done), 0);
                @(negedge clk);
                check(st_done, VECS[vi].use_aux ? "R6 done due" : "R4 done due",
                      int'(st_done), 1);
            end
            // R5 readback of trigger, oldest and newest samples
            read_idx(int'(VECS[vi].pos), got);
            check(got == tval, VECS[vi].use_aux ? "R6 trigger sample" : "R5 trigger sample",
                  int'(got), int'(tval));
            read_idx(0, got);
            expv = tval - SW'(VECS[vi].pos);
            check(got == expv, "R5 oldest", int'(got), int'(expv));
            read_idx(DEPTH - 1, got);
            expv = tval - SW'(VECS[vi].pos) + SW'(DEPTH - 1);
            check(got == expv, "R5 newest", int'(got), int'(expv));
            aux = '0;
            repeat (4) @(negedge clk);
        end

        // R3: triggers in DONE leave state and contents untouched
        local_trig = 1'b1;
        aux = 2'b11;
        repeat (5) @(negedge clk);
        local_trig = 1'b0;
        aux = '0;
        repeat (4) @(negedge clk);
        check(st_done && st_triggered && !st_armed, "R3 done", {st_done, st_armed}, 2'b10);
        read_idx(100, got);
        check(got == tval, "R3 contents", int'(got), int'(tval));

        // R7: trig_out echoes local_trig one edge later
        local_trig = 1'b1;
        @(negedge clk);
        check(trig_out == 1'b1, "R7 high", int'(trig_out), 1);
        local_trig = 1'b0;
        @(negedge clk);
        check(trig_out == 1'b0, "R7 low", int'(trig_out), 0);

        // R2: re-arm clears the finished capture
        wr(2'd0, 1);
        check(st_armed && !st_done && !st_triggered, "R2 rearm",
              {st_armed, st_done, st_triggered}, 3'b100);

        summary();
    end
endmodule